// File: doc/BRIEF.md
# Packet DMA Channel Control Registers

This block is the per-channel register file of a packet-driven disk DMA engine. Software reaches it over a simple memory-mapped read/write bus. It holds a control word, a sticky status byte, the descriptor count, the next-descriptor pointer, a lookup-table base and the input and output FIFO thresholds. A global lock register gates the start operation. The configuration values are driven out to the engine as plain ports.

Control writes become engine commands. The reset bit holds the engine in reset. The start bit produces a single-cycle start pulse. The mask bit gates the channel interrupt. The block tracks the engine state as idle, packet running or register mode. The engine reports back with a done strobe and three error strobes. These set sticky bits in the status byte, and a read of that byte clears them. The channel interrupt is raised while any status bit is set and the mask bit is clear.

Top module: `pdma_chan_regs`

## Requirements
- R1: After reset, descriptor count reads 1, both FIFO thresholds read 0x100, the next pointer and lookup base read 0, the control word reads 0x0003, status reads 0, the lock reads 0, `chan_state` is idle (0), and `irq`, `eng_start` and `eng_rst` are 0.
- R2: Each configuration register is read/write at its byte address and drives its output port from the cycle after the write. The addresses are: count 0x04 (16 bits), next pointer 0x0C (32 bits), lookup base 0x10 (32 bits), input threshold 0x14 (16 bits) and output threshold 0x16 (16 bits). Write data above the register width is dropped. Unmapped addresses read 0.
- R3: A write to the control word (0x00) with bit 7 set is accepted when all of these hold: bit 5 is clear, the reset bit is not held, the engine is not in packet state, and the lock (0xC7) holds 7. An accepted write makes `eng_start` high for exactly the next cycle and sets `chan_state` to packet (1). Bit 7 always reads back 0.
- R4: A start write that is not accepted produces no start pulse and leaves `chan_state` unchanged.
- R5: Control bit 5 is the reset bit. While it is stored, `eng_rst` is 1. Writing it forces `chan_state` to idle (0) and takes priority over bit 7. The first later control write that clears the bit leaves the state idle.
- R6: A control write with bits 7 and 5 clear, made while reset is not held, sets `chan_state` to register mode (2). This applies in every state, including packet.
- R7: `eng_done` in packet state returns `chan_state` to idle, unless a control write in the same cycle decides the state.
- R8: Status (0x02) bits are sticky and set in every state: bit 7 by done, bit 6 by `eng_err[2]` (sequence fault), bit 4 by `eng_err[1]` (unexpected device interrupt), bit 0 by `eng_err[0]` (bus/parity fault). A read returns the current value and clears it. An event in the cycle of the read survives the clear.
- R9: `irq` is 1 exactly when status is nonzero and control bit 8 (mask) is clear.
- R10: The lock register at 0xC7 is 8 bits wide, read/write, and starts are only accepted while it holds 7.
- R11: Control bits 1:0 are stored, read back, and drive `pio_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| eng_done | input | 1 | Engine packet completion strobe |
| eng_err | input | 3 | Engine error strobes: sequence, device interrupt, bus |
| eng_start | output | 1 | Single-cycle packet start pulse |
| eng_rst | output | 1 | Engine logic reset level |
| chan_state | output | 2 | 0 idle, 1 packet, 2 register mode |
| pio_mode | output | 2 | Programmed-I/O mode field |
| desc_count | output | 16 | Descriptor count |
| next_desc | output | 32 | Next-descriptor pointer |
| lut_base | output | 32 | Lookup-table base |
| fifo_in_thr | output | 16 | Input FIFO threshold |
| fifo_out_thr | output | 16 | Output FIFO threshold |
| irq | output | 1 | Channel interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the read-to-clear of the status byte and a new engine event. The bench pulses an error strobe during the status read. That read must return the old value, and the next read must return the new bit. The second pair is control-word commands and the current engine state. The bench sweeps every combination of start and reset bits, lock value and prior state (idle, register, packet), and compares the resulting state and start pulse against a table of expected outcomes.

// File: rtl/pdma_chan_pkg.sv
package pdma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PKT  = 2'd1,
    ST_REG  = 2'd2
  } chan_state_e;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_STAT   = 8'h02;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_NEXT   = 8'h0C;
  localparam logic [7:0] OFS_LUT    = 8'h10;
  localparam logic [7:0] OFS_FIN    = 8'h14;
  localparam logic [7:0] OFS_FOUT   = 8'h16;
  localparam logic [7:0] OFS_LOCK   = 8'hC7;

  localparam int BIT_MASK  = 8;
  localparam int BIT_START = 7;
  localparam int BIT_RST   = 5;

  localparam logic [7:0] LOCK_KEY = 8'h07;
endpackage

// File: rtl/pdma_cfg_reg.sv
module pdma_cfg_reg #(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/pdma_status_sticky.sv
module pdma_status_sticky (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_clr,
  input  logic       ev_done,
  input  logic [2:0] ev_err,
  output logic [7:0] status
);
  logic [7:0] ev_vec;
  logic [7:0] status_nx;

  always_comb begin
    ev_vec    = {ev_done, ev_err[2], 1'b0, ev_err[1], 3'b000, ev_err[0]};
    status_nx = (rd_clr ? 8'h00 : status) | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 8'h00;
    else        status <= status_nx;
  end
endmodule

// File: rtl/pdma_ctrl_word.sv
module pdma_ctrl_word
  import pdma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        wd_mask,
  input  logic        wd_start,
  input  logic        wd_rst,
  input  logic [1:0]  wd_mode,
  input  logic        lock_ok,
  input  logic        ev_done,
  output logic        mask_q,
  output logic        rst_q,
  output logic [1:0]  mode_q,
  output logic        start_q,
  output chan_state_e state_q
);
  logic        mask_nx, rst_nx, start_nx;
  logic [1:0]  mode_nx;
  chan_state_e state_nx;

  always_comb begin
    mask_nx  = mask_q;
    rst_nx   = rst_q;
    mode_nx  = mode_q;
    start_nx = 1'b0;
    state_nx = state_q;
    if (ev_done && state_q == ST_PKT) state_nx = ST_IDLE;
    if (we) begin
      mask_nx = wd_mask;
      mode_nx = wd_mode;
      rst_nx  = wd_rst;
      if (wd_rst) begin
        state_nx = ST_IDLE;
      end else if (wd_start) begin
        if (!rst_q && lock_ok && state_q != ST_PKT) begin
          start_nx = 1'b1;
          state_nx = ST_PKT;
        end
      end else if (rst_q) begin
        state_nx = ST_IDLE;
      end else begin
        state_nx = ST_REG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b0;
      rst_q   <= 1'b0;
      mode_q  <= 2'd3;
      start_q <= 1'b0;
      state_q <= ST_IDLE;
    end else begin
      mask_q  <= mask_nx;
      rst_q   <= rst_nx;
      mode_q  <= mode_nx;
      start_q <= start_nx;
      state_q <= state_nx;
    end
  end
endmodule

// File: rtl/pdma_chan_regs.sv
module pdma_chan_regs
  import pdma_chan_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          CNT_W   = 16,
  parameter int          THR_W   = 16,
  parameter int          PTR_W   = 32,
  parameter int          LUT_W   = 32,
  parameter logic [15:0] THR_RST = 16'h0100,
  parameter logic [15:0] CNT_RST = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_done,
  input  logic [2:0]        eng_err,
  output logic              eng_start,
  output logic              eng_rst,
  output logic [1:0]        chan_state,
  output logic [1:0]        pio_mode,
  output logic [CNT_W-1:0]  desc_count,
  output logic [PTR_W-1:0]  next_desc,
  output logic [LUT_W-1:0]  lut_base,
  output logic [THR_W-1:0]  fifo_in_thr,
  output logic [THR_W-1:0]  fifo_out_thr,
  output logic              irq
);
  localparam int NCFG = 6;

  logic [NCFG-1:0] cfg_we;
  logic            ctrl_we, stat_clr, lock_ok;
  logic            ctrl_mask, ctrl_rst, ctrl_start;
  logic [1:0]      ctrl_mode;
  logic [7:0]      status_q, lock_q;
  chan_state_e     state_q;

  always_comb begin
    ctrl_we  = bus_wr && bus_addr == OFS_CTRL;
    stat_clr = bus_rd && bus_addr == OFS_STAT;
    cfg_we   = '0;
    if (bus_wr) begin
      cfg_we[0] = bus_addr == OFS_COUNT;
      cfg_we[1] = bus_addr == OFS_NEXT;
      cfg_we[2] = bus_addr == OFS_LUT;
      cfg_we[3] = bus_addr == OFS_FIN;
      cfg_we[4] = bus_addr == OFS_FOUT;
      cfg_we[5] = bus_addr == OFS_LOCK;
    end
  end

  pdma_cfg_reg #(.W(CNT_W), .RST(CNT_W'(CNT_RST))) u_count (
    .clk(clk), .rst_n(rst_n), .we(cfg_we[0]), .d(bus_wdata[CNT_W-1:0]), .q(desc_count));
  pdma_cfg_reg #(.W(PTR_W), .RST('0)) u_next (
    .clk(clk), .rst_n(rst_n), .we(cfg_we[1]), .d(bus_wdata[PTR_W-1:0]), .q(next_desc));
  pdma_cfg_reg #(.W(LUT_W), .RST('0)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(cfg_we[2]), .d(bus_wdata[LUT_W-1:0]), .q(lut_base));
  pdma_cfg_reg #(.W(THR_W), .RST(THR_W'(THR_RST))) u_fin (
    .clk(clk), .rst_n(rst_n), .we(cfg_we[3]), .d(bus_wdata[THR_W-1:0]), .q(fifo_in_thr));
  pdma_cfg_reg #(.W(THR_W), .RST(THR_W'(THR_RST))) u_fout (
    .clk(clk), .rst_n(rst_n), .we(cfg_we[4]), .d(bus_wdata[THR_W-1:0]), .q(fifo_out_thr));
  pdma_cfg_reg #(.W(8), .RST(8'h00)) u_lock (
    .clk(clk), .rst_n(rst_n), .we(cfg_we[5]), .d(bus_wdata[7:0]), .q(lock_q));

  assign lock_ok = lock_q == LOCK_KEY;

  pdma_ctrl_word u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we),
    .wd_mask(bus_wdata[BIT_MASK]), .wd_start(bus_wdata[BIT_START]),
    .wd_rst(bus_wdata[BIT_RST]), .wd_mode(bus_wdata[1:0]),
    .lock_ok(lock_ok), .ev_done(eng_done),
    .mask_q(ctrl_mask), .rst_q(ctrl_rst), .mode_q(ctrl_mode),
    .start_q(ctrl_start), .state_q(state_q));

  pdma_status_sticky u_stat (
    .clk(clk), .rst_n(rst_n), .rd_clr(stat_clr),
    .ev_done(eng_done), .ev_err(eng_err), .status(status_q));

  assign eng_start  = ctrl_start;
  assign eng_rst    = ctrl_rst;
  assign chan_state = state_q;
  assign pio_mode   = ctrl_mode;
  assign irq        = (status_q != 8'h00) && !ctrl_mask;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata = DATA_W'({ctrl_mask, 2'b00, ctrl_rst, 3'b000, ctrl_mode});
        OFS_STAT:  bus_rdata = DATA_W'(status_q);
        OFS_COUNT: bus_rdata = DATA_W'(desc_count);
        OFS_NEXT:  bus_rdata = DATA_W'(next_desc);
        OFS_LUT:   bus_rdata = DATA_W'(lut_base);
        OFS_FIN:   bus_rdata = DATA_W'(fifo_in_thr);
        OFS_FOUT:  bus_rdata = DATA_W'(fifo_out_thr);
        OFS_LOCK:  bus_rdata = DATA_W'(lock_q);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pdma_chan_regs_chk.sv
module pdma_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic       eng_rst,
  input logic [1:0] chan_state,
  input logic       eng_done,
  input logic       ctrl_we,
  input logic       stat_clr,
  input logic [7:0] status_q,
  input logic       irq
);
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  a_r3_start_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> chan_state == 2'd1);
  a_r4_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == 2'd1) |=> !eng_start);
  a_r5_rst_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> chan_state == 2'd0);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && chan_state == 2'd1 && !ctrl_we) |=> chan_state == 2'd0);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h00) |-> !irq);
endmodule

bind pdma_chan_regs pdma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_rst(eng_rst),
  .chan_state(chan_state), .eng_done(eng_done), .ctrl_we(ctrl_we),
  .stat_clr(stat_clr), .status_q(status_q), .irq(irq));

// File: tb/test_pdma_chan_regs.sv
`timescale 1ns/1ps
module test_pdma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        eng_done;
  logic [2:0]  eng_err;
  logic        eng_start, eng_rst, irq;
  logic [1:0]  chan_state, pio_mode;
  logic [15:0] desc_count, fifo_in_thr, fifo_out_thr;
  logic [31:0] next_desc, lut_base;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pdma_chan_regs i_pdma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_start(eng_start), .eng_rst(eng_rst), .chan_state(chan_state), .pio_mode(pio_mode),
    .desc_count(desc_count), .next_desc(next_desc), .lut_base(lut_base),
    .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic go_idle();
    wr(8'h00, 32'h0123);
    wr(8'h00, 32'h0003);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [3];
    int exp_st;
    bit exp_go;
    string req;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h0000_0000;
    rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    eng_done = 1'b0; eng_err = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h04, v); chk("R1 count", v, 32'h1);
    rd(8'h14, v); chk("R1 fifo_in", v, 32'h100);
    rd(8'h16, v); chk("R1 fifo_out", v, 32'h100);
    rd(8'h0C, v); chk("R1 next", v, 32'h0);
    rd(8'h10, v); chk("R1 lut", v, 32'h0);
    rd(8'h00, v); chk("R1 ctrl", v, 32'h3);
    rd(8'h02, v); chk("R1 status", v, 32'h0);
    rd(8'hC7, v); chk("R1 lock", v, 32'h0);
    chk("R1 state", chan_state, 0); chk("R1 irq", irq, 0);
    chk("R1 start", eng_start, 0); chk("R1 rst", eng_rst, 0);

    // R2 configuration sweep
    foreach (pats[i]) begin
      wr(8'h04, pats[i]); chk("R2 count port", desc_count, pats[i] & 32'hFFFF);
      rd(8'h04, v);       chk("R2 count rd", v, pats[i] & 32'hFFFF);
      wr(8'h0C, pats[i]); chk("R2 next port", next_desc, pats[i]);
      rd(8'h0C, v);       chk("R2 next rd", v, pats[i]);
      wr(8'h10, ~pats[i]); chk("R2 lut port", lut_base, ~pats[i]);
      rd(8'h10, v);       chk("R2 lut rd", v, ~pats[i]);
      wr(8'h14, pats[i]); chk("R2 fin port", fifo_in_thr, pats[i] & 32'hFFFF);
      rd(8'h14, v);       chk("R2 fin rd", v, pats[i] & 32'hFFFF);
      wr(8'h16, ~pats[i]); chk("R2 fout port", fifo_out_thr, ~pats[i] & 32'hFFFF);
      rd(8'h16, v);       chk("R2 fout rd", v, ~pats[i] & 32'hFFFF);
      wr(8'hC7, pats[i]); rd(8'hC7, v); chk("R10 lock rd", v, pats[i] & 32'hFF);
    end
    rd(8'h08, v); chk("R2 unmapped", v, 0);

    // R11 mode field
    for (int m = 0; m < 4; m++) begin
      wr(8'h00, m); chk("R11 pio_mode", pio_mode, m);
      rd(8'h00, v); chk("R11 ctrl rd", v, m);
    end

    // R3 R4 R5 R6 command sweep over prior state, bits and lock
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++)
          for (int l = 0; l < 2; l++) begin
            go_idle();
            if (p == 2) wr(8'h00, 32'h0003);
            if (p == 1) begin wr(8'hC7, 32'h7); wr(8'h00, 32'h0083); end
            wr(8'hC7, l ? 32'h7 : 32'h5);
            chk("R1 setup state", chan_state, p);
            wr(8'h00, (s << 7) | (r << 5) | 3);
            exp_go = (r == 0) && (s == 1) && (l == 1) && (p != 1);
            exp_st = r ? 0 : (s ? (exp_go ? 1 : p) : 2);
            req = r ? "R5" : (s ? (exp_go ? "R3" : "R4") : "R6");
            chk({req, " state"}, chan_state, exp_st);
            chk({req, " start pulse"}, eng_start, exp_go);
            chk("R5 rst level", eng_rst, r);
            rd(8'h00, v); chk("R3 start reads 0", v & 32'h80, 0);
            chk("R3 pulse ends", eng_start, 0);
            if (r) begin wr(8'h00, 32'h0003); chk("R5 release idle", chan_state, 0); end
          end

    // R4 start while reset held, lock ok
    wr(8'hC7, 32'h7); wr(8'h00, 32'h0123); wr(8'h00, 32'h0083);
    chk("R4 held rst start", eng_start, 0); chk("R4 held rst state", chan_state, 0);

    // R7 done from packet, R8 status, R9 irq
    rd(8'h02, v);
    wr(8'h00, 32'h0083); chk("R3 start", eng_start, 1);
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    chk("R7 done idle", chan_state, 0);
    chk("R9 irq done", irq, 1);
    rd(8'h02, v); chk("R8 done bit", v, 32'h80);
    rd(8'h02, v); chk("R8 cleared", v, 0);
    chk("R9 irq clear", irq, 0);
    for (int e = 0; e < 3; e++) begin
      eng_err = 3'b001 << e; @(negedge clk); eng_err = 3'b000;
      rd(8'h02, v); chk("R8 err bit", v, (e == 0) ? 32'h01 : (e == 1) ? 32'h10 : 32'h40);
    end
    wr(8'h00, 32'h0103);
    eng_err = 3'b001; @(negedge clk); eng_err = 3'b000;
    chk("R9 masked", irq, 0);
    wr(8'h00, 32'h0003); chk("R9 unmasked", irq, 1);
    rd(8'h02, v); chk("R8 read", v, 32'h01);
    // R8 event in the cycle of the read
    eng_err = 3'b100; rd(8'h02, v); eng_err = 3'b000;
    chk("R8 same-cycle read old", v, 0);
    rd(8'h02, v); chk("R8 same-cycle kept", v, 32'h40);
    // R7 done outside packet leaves state
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    chk("R7 done in reg mode", chan_state, 2);
    rd(8'h02, v); chk("R8 done sets anywhere", v, 32'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule